// File: doc/BRIEF.md
# Frame Clock Ratio Tracker

This block runs entirely on the system clock and watches the sample-rate frame clock. It measures how many system clocks fall between successive frame-clock rising edges. From that count it decides whether the system clock runs at 256 or 384 times the sample rate. Once the same ratio has been seen on two frames in a row, it reports lock and produces a one-cycle sample tick per frame. The interpolation filters downstream use that tick as their per-sample timing.

While locked, the block compares each frame edge with its own free-running tick phase. A small phase offset is tolerated, and the tick keeps running undisturbed. A larger offset is treated as a slip. The tick counter is then snapped back to the frame edge, and the output stream is patched to avoid an audible click. When the edge arrived late, the realigned tick is flagged as a repeat of the previous sample. When the edge arrived early, the next sample the receiver marks valid is flagged as dropped.

Top module: `frame_ratio_tracker`

## Requirements
- R1: During and right after reset, `locked`, `ratio_hi`, `tick`, `repeat_smp` and `drop_smp` are all 0.
- R2: A frame period of 248 to 264 system clocks classifies as the 256x ratio. Two consecutive such periods set `locked` with `ratio_hi` = 0.
- R3: A frame period of 376 to 392 system clocks classifies as the 384x ratio. Two consecutive such periods set `locked` with `ratio_hi` = 1.
- R4: A frame period outside both windows (for example 247, 300 or 375) clears `locked`, or keeps it clear.
- R5: While locked, a period that classifies as the other ratio clears `locked`. Two such periods in a row then relock at the new ratio.
- R6: While locked, `tick` pulses for one cycle per frame. When the frame clock is already high before clock edge k, the aligned tick is high in the cycle after edge k+2. `tick` is never high while unlocked.
- R7: While locked, an edge offset of at most a quarter frame (64 clocks at 256x) causes no realignment and no repeat. If that frame's period is outside the locked ratio's window, `locked` clears.
- R8: While locked, an edge late by more than a quarter and at most half a frame realigns the tick to that edge. The realigned tick carries `repeat_smp` = 1 in the same cycle.
- R9: While locked, an edge early by more than a quarter frame realigns the tick with `repeat_smp` = 0. The next `smp_valid` pulse is then flagged by `drop_smp`, which is high in the same cycle as that `smp_valid`.
- R10: If no frame rising edge arrives for more than 393 cycles, `locked` clears.
- R11: `ratio_hi` does not change while `locked` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Sample-rate frame clock, asynchronous to clk |
| smp_valid | input | 1 | One-cycle pulse from the receiver when a new sample is ready |
| ratio_hi | output | 1 | Detected ratio: 0 = 256x, 1 = 384x |
| locked | output | 1 | Ratio confirmed and tick running |
| tick | output | 1 | Per-sample strobe for the filters |
| repeat_smp | output | 1 | Realigned tick re-issues the previous sample |
| drop_smp | output | 1 | Current smp_valid sample is to be discarded |

## Verification
A frame-clock rising edge passes two synchroniser flops before the rising-edge detect. The classification, lock and realignment registers update on the third clock edge. So `locked`, `tick` and `repeat_smp` respond in the cycle after that edge, which the bench sees at the third falling edge after it drives the frame clock high. `drop_smp` is combinational on `smp_valid`, so the bench samples it 1 ns after raising `smp_valid`, before the next rising edge clears the pending flag. Lock state and ratio are checked only at the end of a frame. By then, every measurement closed within that run has settled.

// File: rtl/frame_ratio_tracker.sv
module frame_ratio_tracker #(
  parameter int NOM_LO = 256,
  parameter int NOM_HI = 384,
  parameter int TOL    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic smp_valid,
  output logic ratio_hi,
  output logic locked,
  output logic tick,
  output logic repeat_smp,
  output logic drop_smp
);
  localparam int LIMIT = NOM_HI + TOL + 1;
  localparam int CW    = $clog2(LIMIT + 2);
  localparam int PW    = $clog2(NOM_HI + 1);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);
  localparam logic [CW-1:0] LO_MIN = CW'(NOM_LO - TOL);
  localparam logic [CW-1:0] LO_MAX = CW'(NOM_LO + TOL);
  localparam logic [CW-1:0] HI_MIN = CW'(NOM_HI - TOL);
  localparam logic [CW-1:0] HI_MAX = CW'(NOM_HI + TOL);
  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_LO   = 2'b01;
  localparam logic [1:0] C_HI   = 2'b10;

  logic          s1, s2, fd, seen, rep, pend;
  logic [CW-1:0] cnt, period;
  logic [PW-1:0] ph, n_len, d, quarter, half;
  logic [1:0]    cls, prev, own, other;
  logic          rise, slip, late;

  assign rise    = s2 & ~fd;
  assign period  = cnt + 1'b1;
  assign cls     = (period >= LO_MIN && period <= LO_MAX) ? C_LO :
                   (period >= HI_MIN && period <= HI_MAX) ? C_HI : C_NONE;
  assign own     = ratio_hi ? C_HI : C_LO;
  assign other   = ratio_hi ? C_LO : C_HI;
  assign n_len   = ratio_hi ? PW'(NOM_HI) : PW'(NOM_LO);
  assign quarter = n_len >> 2;
  assign half    = n_len >> 1;
  assign d       = (ph == n_len - 1'b1) ? '0 : ph + 1'b1;
  assign slip    = (d > quarter) && (d < n_len - quarter);
  assign late    = (d <= half);

  assign tick       = locked & (ph == '0);
  assign repeat_smp = rep;
  assign drop_smp   = pend & smp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; fd <= 1'b0;
      seen <= 1'b0; rep <= 1'b0; pend <= 1'b0;
      cnt <= '0; ph <= '0; prev <= C_NONE;
      locked <= 1'b0; ratio_hi <= 1'b0;
    end else begin
      s1 <= frame_clk;
      s2 <= s1;
      fd <= s2;
      rep <= 1'b0;
      if (drop_smp) pend <= 1'b0;
      if (locked) ph <= (ph == n_len - 1'b1) ? '0 : ph + 1'b1;
      else        ph <= '0;

      if (rise) begin
        cnt  <= '0;
        seen <= 1'b1;
        if (seen) begin
          if (locked && cls != other && slip) begin
            ph  <= '0;
            rep <= late;
            if (!late) pend <= 1'b1;
          end else if (locked && cls == own) begin
            prev <= own;
          end else if (!locked && cls != C_NONE && cls == prev) begin
            locked   <= 1'b1;
            ratio_hi <= (cls == C_HI);
            ph       <= '0;
          end else begin
            locked <= 1'b0;
            prev   <= cls;
            pend   <= 1'b0;
          end
        end
      end else begin
        if (cnt != LIM) cnt <= cnt + 1'b1;
        if (cnt == LIM - 1'b1) begin
          locked <= 1'b0;
          prev   <= C_NONE;
          pend   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/frame_ratio_tracker_chk.sv
module frame_ratio_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic ratio_hi,
  input logic locked,
  input logic tick,
  input logic repeat_smp,
  input logic drop_smp
);
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_lock_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> tick);
  p_repeat_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_smp |-> tick);
  p_drop_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_smp |-> locked);
  p_ratio_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(ratio_hi));
endmodule

bind frame_ratio_tracker frame_ratio_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ratio_hi(ratio_hi), .locked(locked),
  .tick(tick), .repeat_smp(repeat_smp), .drop_smp(drop_smp)
);

// File: tb/frame_ratio_tracker_bench.sv
`timescale 1ns/1ps
module frame_ratio_tracker_bench;
  logic clk = 1'b0, rst_n = 1'b0, frame_clk = 1'b0, smp_valid = 1'b0;
  logic ratio_hi, locked, tick, repeat_smp, drop_smp;
  int checks = 0, errors = 0;
  int f_ticks, f_tick3, f_rep, f_drop;

  always #2.5 clk = ~clk;

  frame_ratio_tracker u_frame_ratio_tracker (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .smp_valid(smp_valid),
    .ratio_hi(ratio_hi), .locked(locked), .tick(tick),
    .repeat_smp(repeat_smp), .drop_smp(drop_smp)
  );

  // period, frames, expected locked, expected ratio_hi
  localparam int VEC [10][4] = '{
    '{256, 3, 1, 0}, '{384, 3, 1, 1}, '{250, 3, 1, 0}, '{392, 3, 1, 1},
    '{376, 3, 1, 1}, '{300, 3, 0, 0}, '{264, 3, 1, 0}, '{247, 3, 0, 0},
    '{375, 3, 0, 0}, '{256, 4, 1, 0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int p);
    f_ticks = 0; f_tick3 = 0; f_rep = 0; f_drop = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (tick) begin f_ticks++; if (i == 3) f_tick3 = 1; end
      if (repeat_smp) f_rep = 1;
      if (i == 0) frame_clk = 1'b1;
      if (i == p / 2) begin
        frame_clk = 1'b0;
        smp_valid = 1'b1;
        #1;
        if (drop_smp) f_drop = 1;
      end
      if (i == p / 2 + 1) smp_valid = 1'b0;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(locked == 0 && tick == 0 && repeat_smp == 0 && drop_smp == 0 && ratio_hi == 0,
        "R1 in reset", {locked, tick, repeat_smp, drop_smp, ratio_hi}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(locked == 0 && tick == 0 && ratio_hi == 0, "R1 after reset",
        {locked, tick, ratio_hi}, 0);

    // R2 R3 R4 R5 R11: classification table
    foreach (VEC[v]) begin
      for (int f = 0; f < VEC[v][1]; f++) frame(VEC[v][0]);
      chk(locked == VEC[v][2], $sformatf("R2/R3/R4/R5 lock period=%0d", VEC[v][0]),
          locked, VEC[v][2]);
      if (VEC[v][2] == 1)
        chk(ratio_hi == VEC[v][3], $sformatf("R11 ratio period=%0d", VEC[v][0]),
            ratio_hi, VEC[v][3]);
    end

    // R6: aligned tick at 256x
    for (int f = 0; f < 2; f++) begin
      frame(256);
      chk(f_ticks == 1 && f_tick3 == 1, "R6 tick position 256x", f_ticks * 10 + f_tick3, 11);
    end

    // R8: late by 65
    frame(321);
    frame(256);
    chk(f_rep == 1 && f_tick3 == 1, "R8 repeat on realigned tick", f_rep * 10 + f_tick3, 11);
    chk(locked == 1, "R8 stays locked", locked, 1);
    chk(f_drop == 0, "R8 no drop", f_drop, 0);

    // R9: early by 65
    frame(191);
    frame(256);
    chk(f_tick3 == 1 && f_rep == 0, "R9 realign without repeat", f_tick3 * 10 + f_rep, 10);
    chk(f_drop == 1, "R9 next sample dropped", f_drop, 1);
    chk(locked == 1, "R9 stays locked", locked, 1);

    // R7: offset exactly a quarter, period invalid -> unlock, no repeat
    frame(320);
    frame(256);
    chk(f_rep == 0, "R7 quarter offset no repeat", f_rep, 0);
    chk(locked == 0, "R7 out-of-window period unlocks", locked, 0);
    chk(f_ticks == 0, "R6 no tick while unlocked", f_ticks, 0);

    // R7: small tolerated offset
    for (int f = 0; f < 3; f++) frame(256);
    frame(262);
    frame(256);
    chk(locked == 1 && f_rep == 0, "R7 small offset tolerated", locked * 10 + f_rep, 10);
    chk(f_ticks == 1 && f_tick3 == 0, "R7 tick not realigned", f_ticks * 10 + f_tick3, 10);

    // R3 R6: tick at 384x
    for (int f = 0; f < 3; f++) frame(384);
    frame(384);
    chk(locked == 1 && ratio_hi == 1, "R3 relock 384x", locked * 10 + ratio_hi, 11);
    chk(f_ticks == 1 && f_tick3 == 1, "R6 tick position 384x", f_ticks * 10 + f_tick3, 11);

    // R10: frame clock stops
    repeat (420) @(negedge clk);
    chk(locked == 0, "R10 timeout clears lock", locked, 0);

    summary();
  end
endmodule